// File: doc/BRIEF.md
# Receive Self-Test Pattern Checker

This block sits on the receive side of a serial link. During a built-in self-test it compares the decoded 8-bit characters against a locally generated copy of the 511-character test pattern. It reports progress and errors to the host through the status and data pins that the receive FIFO uses in normal operation. It locks onto the pattern by finding its start character. It then steps a 9-bit reference generator once per received character and flags every miscompare. If errors pile up inside a sliding window of 28 characters, it drops lock and goes back to hunting.

Two indications reach the host: a loop flag and a violation bit. When the receive FIFO is in use, both are sticky: an event stays set until the host has observed it. When the FIFO is bypassed, both are dynamic: an event that arrives while the device is not addressed, or not selected, is lost. While the test runs, the block blocks writes into the FIFO and forces the FIFO status it passes on to show empty.

The controller has three states:
- `ST_IDLE`: the test is off.
- `ST_HUNT`: looking for the start character 0x00.
- `ST_LOCKED`: comparing characters.

Its transitions are:
- IDLE→HUNT when the active-low enable is sampled low.
- HUNT→LOCKED when a valid 0x00 character arrives.
- LOCKED→HUNT on loss of lock.
- Any state→IDLE when the enable is sampled high.

Top module: `rx_bist_checker`

## Requirements
- R1: When the enable (`bist_en_n`) is first sampled low in ST_IDLE, the loop flag is set at that edge whatever `ce_n` is. It reads 1 as soon as the chip is addressed.
- R2: In ST_HUNT the loop flag stays 1 until a valid character 0x00 is received. That character moves the block to ST_LOCKED, and the flag then reads 0.
- R3: The reference sequence starts at state 0x100 and steps with s' = {s[7:0], s[8]^s[4]}. The expected character is s[7:0], so the start character is 0x00 and the last one is 0x80. The loop flag pulses 1 for one cycle after the last character of each 511-character loop.
- R4: A character is in error when it differs from the expected one. Lock is lost, and the flag returns to 1 in ST_HUNT, on the character that makes 14 of the last 28 checked characters erroneous. Errors spread so that any 28-character window holds at most 13 keep lock.
- R5: With the FIFO in use (`fifo_bypass`=0), a loop event and a miscompare stay set until observed. The loop flag clears once `ce_n` has been sampled low. The violation bit clears once a selected read (`ce_n`=0 and `rd_en_n`=0) has been sampled.
- R6: With `fifo_bypass`=1, neither indication is held. Each shows only the event of the last character, so events that occur while the chip is not addressed are lost.
- R7: `violation_oe` is 1 only after a sampled selected read. `loop_flag_oe` is 1 only after `ce_n` has been sampled low. Both are 0 outside the test.
- R8: While the test is active, `fifo_empty_out`=1 and `fifo_half_out`=0. `fifo_wr_inhibit` is 1 when the FIFO is in use. Outside the test, both flags pass `fifo_empty_in` and `fifo_half_in` through, and the inhibit is 0.
- R9: Sampling `bist_en_n` high returns the block to ST_IDLE. From the next cycle, the loop flag and the violation bit read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bist_en_n | input | 1 | Self-test enable, active low |
| fifo_bypass | input | 1 | 1 = receive FIFO bypassed (dynamic flags) |
| ce_n | input | 1 | Chip enable (addressing), active low |
| rd_en_n | input | 1 | Read enable, active low |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_char | input | 8 | Decoded received character |
| fifo_empty_in | input | 1 | Real FIFO empty status |
| fifo_half_in | input | 1 | Real FIFO half-full status |
| loop_flag | output | 1 | Loop / synchronisation indication |
| loop_flag_oe | output | 1 | Driver enable for the loop flag |
| violation | output | 1 | Miscompare indication |
| violation_oe | output | 1 | Driver enable for the violation bit |
| fifo_empty_out | output | 1 | Empty status shown to the host |
| fifo_half_out | output | 1 | Half-full status shown to the host |
| fifo_wr_inhibit | output | 1 | Suspends writes into the receive FIFO |

## Verification
Every result is registered, so a character or a control change presented in one cycle shows on the outputs exactly one clock later. The FIFO status overrides follow the state register, so they also change one clock after the enable is sampled. The bench drives each input right after a falling edge, lets one rising edge pass, and samples at the following falling edge. Every check therefore reads the response to exactly one stimulus. The sticky tests deliberately step through several characters with the chip unaddressed. They then confirm that the held value appears on the first addressed cycle and is gone one cycle later.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } rxb_state_e;

    localparam int          CHAR_W     = 8;
    localparam int          REF_W      = 9;
    localparam logic [8:0]  SEQ_START  = 9'h100;
    localparam logic [7:0]  START_CHAR = SEQ_START[7:0];

    // One step of the 511-state reference generator.
    function automatic logic [8:0] ref_step(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

endpackage

// File: rtl/rxb_ref_lfsr.sv
module rxb_ref_lfsr
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output logic [CHAR_W-1:0] exp_char,
    output logic              last_sym
);

    logic [REF_W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_START;
        end else if (load) begin
            state_q <= ref_step(SEQ_START);
        end else if (advance) begin
            state_q <= ref_step(state_q);
        end
    end

    assign exp_char = state_q[CHAR_W-1:0];
    assign last_sym = (ref_step(state_q) == SEQ_START);

    AST_REF_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R3

endmodule

// File: rtl/rxb_err_window.sv
module rxb_err_window #(
    parameter int WINDOW = 28,
    parameter int THRESH = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift,
    input  logic err_in,
    output logic lose_lock
);

    localparam int CNT_W = $clog2(WINDOW + 1);

    logic [WINDOW-1:0] hist_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;

    always_comb begin
        cnt_nxt   = cnt_q + CNT_W'(err_in) - CNT_W'(hist_q[WINDOW-1]);
        lose_lock = shift && (cnt_nxt >= CNT_W'(THRESH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (clear || lose_lock) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (shift) begin
            hist_q <= {hist_q[WINDOW-2:0], err_in};
            cnt_q  <= cnt_nxt;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(THRESH)); // R4
    AST_CNT_TRACKS_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) == $countones(hist_q)); // R4

endmodule

// File: rtl/rxb_flag_ctrl.sv
module rxb_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic entry,
    input  logic bypass,
    input  logic ev_loop,
    input  logic ev_err,
    input  logic ce_n,
    input  logic rd_en_n,
    output logic loop_flag,
    output logic loop_oe,
    output logic viol,
    output logic viol_oe
);

    logic ce_q;
    logic sel_q;
    logic loop_q;
    logic viol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q  <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            ce_q  <= !ce_n;
            sel_q <= !ce_n && !rd_en_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loop_q <= 1'b0;
            viol_q <= 1'b0;
        end else if (entry) begin
            loop_q <= 1'b1;
            viol_q <= 1'b0;
        end else if (!active) begin
            loop_q <= 1'b0;
            viol_q <= 1'b0;
        end else if (bypass) begin
            loop_q <= ev_loop;
            viol_q <= ev_err;
        end else begin
            loop_q <= ev_loop || (loop_q && !ce_q);
            viol_q <= ev_err  || (viol_q && !sel_q);
        end
    end

    assign loop_flag = loop_q && active;
    assign viol      = viol_q && active;
    assign loop_oe   = ce_q && active;
    assign viol_oe   = sel_q && active;

    AST_LOOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bypass && loop_q && !ce_q) |=> loop_q); // R5
    AST_VIOL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bypass && viol_q && !sel_q) |=> viol_q); // R5
    AST_BYPASS_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bypass && !ev_loop && !ev_err) |=> (!loop_q && !viol_q)); // R6
    AST_VIOL_OE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        viol_oe |-> $past(!ce_n && !rd_en_n)); // R7

endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker
    import rxb_pkg::*;
#(
    parameter int WINDOW = 28,
    parameter int THRESH = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_en_n,
    input  logic              fifo_bypass,
    input  logic              ce_n,
    input  logic              rd_en_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              fifo_empty_in,
    input  logic              fifo_half_in,
    output logic              loop_flag,
    output logic              loop_flag_oe,
    output logic              violation,
    output logic              violation_oe,
    output logic              fifo_empty_out,
    output logic              fifo_half_out,
    output logic              fifo_wr_inhibit
);

    rxb_state_e        state_q;
    rxb_state_e        state_d;
    logic              active;
    logic              entry;
    logic              lock_hit;
    logic              shift;
    logic              miscmp;
    logic              ev_loop;
    logic              lose_lock;
    logic              last_sym;
    logic [CHAR_W-1:0] exp_char;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-character events.
    always_comb begin
        state_d  = state_q;
        entry    = 1'b0;
        lock_hit = 1'b0;
        shift    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!bist_en_n) begin
                    entry   = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (bist_en_n) begin
                    state_d = ST_IDLE;
                end else if (rx_valid && rx_char == START_CHAR) begin
                    lock_hit = 1'b1;
                    state_d  = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (bist_en_n) begin
                    state_d = ST_IDLE;
                end else begin
                    shift = rx_valid;
                    if (lose_lock) begin
                        state_d = ST_HUNT;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        active   = (state_q != ST_IDLE);
        miscmp   = shift && (rx_char != exp_char);
        ev_loop  = ((state_q == ST_HUNT) && !lock_hit)
                   || (shift && last_sym) || lose_lock;
        fifo_empty_out  = active ? 1'b1 : fifo_empty_in;
        fifo_half_out   = active ? 1'b0 : fifo_half_in;
        fifo_wr_inhibit = active && !fifo_bypass;
    end

    rxb_ref_lfsr u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_hit),
        .advance  (shift),
        .exp_char (exp_char),
        .last_sym (last_sym)
    );

    rxb_err_window #(
        .WINDOW (WINDOW),
        .THRESH (THRESH)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q != ST_LOCKED),
        .shift     (shift),
        .err_in    (miscmp),
        .lose_lock (lose_lock)
    );

    rxb_flag_ctrl u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .entry     (entry),
        .bypass    (fifo_bypass),
        .ev_loop   (ev_loop),
        .ev_err    (miscmp),
        .ce_n      (ce_n),
        .rd_en_n   (rd_en_n),
        .loop_flag (loop_flag),
        .loop_oe   (loop_flag_oe),
        .viol      (violation),
        .viol_oe   (violation_oe)
    );

    AST_ENTRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !bist_en_n) |=> loop_flag); // R1
    AST_HUNT_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !bist_en_n && !(rx_valid && rx_char == START_CHAR))
        |=> loop_flag); // R2
    AST_INHIBIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_inhibit |-> (fifo_empty_out && !fifo_half_out)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!loop_flag && !violation && !violation_oe)); // R9

endmodule

// File: tb/rx_bist_checker_bench.sv
`timescale 1ns/1ps
module rx_bist_checker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bist_en_n = 1'b1;
    logic       fifo_bypass = 1'b0;
    logic       ce_n = 1'b1;
    logic       rd_en_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic       fifo_empty_in = 1'b0;
    logic       fifo_half_in = 1'b1;
    logic       loop_flag, loop_flag_oe, violation, violation_oe;
    logic       fifo_empty_out, fifo_half_out, fifo_wr_inhibit;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [8:0] exp_s = 9'h100;

    always #2.5 clk = ~clk;

    rx_bist_checker u_rx_bist_checker (
        .clk(clk), .rst_n(rst_n), .bist_en_n(bist_en_n), .fifo_bypass(fifo_bypass),
        .ce_n(ce_n), .rd_en_n(rd_en_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .fifo_empty_in(fifo_empty_in), .fifo_half_in(fifo_half_in),
        .loop_flag(loop_flag), .loop_flag_oe(loop_flag_oe),
        .violation(violation), .violation_oe(violation_oe),
        .fifo_empty_out(fifo_empty_out), .fifo_half_out(fifo_half_out),
        .fifo_wr_inhibit(fifo_wr_inhibit)
    );

    function automatic logic [8:0] nx(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one cycle of input, let one rising edge pass, return at falling edge.
    task automatic step(input logic v, input logic [7:0] c);
        rx_valid = v;
        rx_char  = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lock_on();
        step(1'b1, 8'h00);
        exp_s = nx(9'h100);
    endtask

    task automatic good();
        step(1'b1, exp_s[7:0]);
        exp_s = nx(exp_s);
    endtask

    task automatic bad();
        step(1'b1, exp_s[7:0] ^ 8'h5A);
        exp_s = nx(exp_s);
    endtask

    task automatic restart(input logic byp);
        bist_en_n = 1'b1;
        step(1'b0, 8'h00);
        fifo_bypass = byp;
        bist_en_n = 1'b0;
        step(1'b0, 8'h00);
    endtask

    task automatic t_reset();
        chk("R9 reset loop_flag", loop_flag, 0);
        chk("R9 reset violation", violation, 0);
        chk("R7 reset loop_flag_oe", loop_flag_oe, 0);
        chk("R8 reset empty passthrough", fifo_empty_out, 0);
        chk("R8 reset half passthrough", fifo_half_out, 1);
        chk("R8 reset inhibit", fifo_wr_inhibit, 0);
    endtask

    task automatic t_entry();
        ce_n = 1'b1;
        bist_en_n = 1'b0;
        step(1'b0, 8'h00);
        chk("R7 loop_oe low while unaddressed", loop_flag_oe, 0);
        chk("R8 forced empty", fifo_empty_out, 1);
        chk("R8 forced not half", fifo_half_out, 0);
        chk("R8 write inhibit", fifo_wr_inhibit, 1);
        ce_n = 1'b0;
        step(1'b0, 8'h00);
        chk("R1 flag set on entry", loop_flag, 1);
        chk("R7 loop_oe after ce sampled", loop_flag_oe, 1);
    endtask

    task automatic t_hunt();
        step(1'b1, 8'h33);
        chk("R2 flag held in hunt", loop_flag, 1);
        step(1'b1, 8'h80);
        chk("R2 flag held on non-start char", loop_flag, 1);
        lock_on();
        chk("R2 flag low after start char", loop_flag, 0);
    endtask

    task automatic t_full_loop();
        int bad_seen = 0;
        for (int i = 1; i <= 509; i++) begin
            good();
            if (loop_flag !== 1'b0 || violation !== 1'b0) bad_seen++;
        end
        chk("R3 quiet through loop body", bad_seen, 0);
        chk("R3 last reference char is 0x80", exp_s[7:0], 8'h80);
        good();
        chk("R3 pulse on last symbol", loop_flag, 1);
        good();
        chk("R3 pulse lasts one cycle", loop_flag, 0);
        chk("R3 start char matches in lock", violation, 0);
    endtask

    task automatic t_lol();
        rd_en_n = 1'b0;
        for (int i = 0; i < 13; i++) bad();
        chk("R4 13 errors keep lock", loop_flag, 0);
        chk("R4 miscompare flagged", violation, 1);
        chk("R7 viol_oe on selected read", violation_oe, 1);
        bad();
        chk("R4 14th error drops lock", loop_flag, 1);
        step(1'b1, 8'h21);
        chk("R4 back in hunt", loop_flag, 1);
        lock_on();
        chk("R4 relock on start char", loop_flag, 0);
    endtask

    task automatic t_slide();
        for (int i = 0; i < 13; i++) bad();
        for (int i = 0; i < 15; i++) good();
        bad();
        chk("R4 sliding window 13 of 28 keeps lock", loop_flag, 0);
        good();
        chk("R4 still locked", loop_flag, 0);
    endtask

    task automatic t_oe();
        rd_en_n = 1'b1;
        bad();
        chk("R7 viol_oe low without read", violation_oe, 0);
        chk("R7 loop_oe high while addressed", loop_flag_oe, 1);
        ce_n = 1'b1;
        good();
        chk("R7 loop_oe low after ce high", loop_flag_oe, 0);
        ce_n = 1'b0;
        rd_en_n = 1'b0;
    endtask

    task automatic t_sticky();
        restart(1'b0);
        ce_n = 1'b1;
        rd_en_n = 1'b1;
        step(1'b0, 8'h00);
        lock_on();
        bad();
        good();
        good();
        ce_n = 1'b0;
        rd_en_n = 1'b0;
        good();
        chk("R5 loop event held until addressed", loop_flag, 1);
        chk("R5 miscompare held until read", violation, 1);
        good();
        chk("R5 loop cleared after observed", loop_flag, 0);
        chk("R5 violation cleared after read", violation, 0);
    endtask

    task automatic t_bypass();
        restart(1'b1);
        chk("R8 bypass no inhibit", fifo_wr_inhibit, 0);
        chk("R8 bypass forced empty", fifo_empty_out, 1);
        ce_n = 1'b1;
        rd_en_n = 1'b1;
        step(1'b0, 8'h00);
        lock_on();
        bad();
        good();
        ce_n = 1'b0;
        rd_en_n = 1'b0;
        good();
        chk("R6 loop event lost in bypass", loop_flag, 0);
        chk("R6 miscompare lost in bypass", violation, 0);
        bad();
        chk("R6 dynamic miscompare", violation, 1);
        good();
        chk("R6 dynamic miscompare clears", violation, 0);
    endtask

    task automatic t_exit();
        bad();
        bist_en_n = 1'b1;
        step(1'b0, 8'h00);
        chk("R9 loop flag cleared on exit", loop_flag, 0);
        chk("R9 violation cleared on exit", violation, 0);
        chk("R8 empty restored", fifo_empty_out, 0);
        chk("R8 half restored", fifo_half_out, 1);
        chk("R8 inhibit released", fifo_wr_inhibit, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_entry();
        t_hunt();
        t_full_loop();
        t_lol();
        t_slide();
        t_oe();
        t_sticky();
        t_bypass();
        t_exit();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule